// File: doc/BRIEF.md
# Free-running timer with compare and shared capture storage

A 16-bit up-counter advanced by an external prescaled clock-enable pulse. It has two 8-bit compare registers and an input capture path that timestamps edges on an external pin. The capture has no register of its own. In narrow capture mode it writes the counter's low byte into compare register A. In wide capture mode it writes the low byte into compare register A and the high byte into compare register B. All state is reached through a small byte-wide register port. The four event flags also leave the block as plain level outputs, for an interrupt controller outside it.

Register addresses on `bus_addr`:
- 0: control.
- 1: counter low byte.
- 2: counter high-byte staging latch.
- 3: compare A.
- 4: compare B.
- 5: flags.

Control bits:
- [2:0]: clock select. Zero stops the counter; any other value counts on `tick`.
- [3]: clear-on-match.
- [4]: capture enable.
- [5]: wide capture.
- [6]: edge polarity, 1 for rising and 0 for falling.
- [7]: noise filter enable.

Flag bits:
- [0]: overflow.
- [1]: capture.
- [2]: match A.
- [3]: match B.

The register port has no handshake. A write takes effect at the clock edge where `bus_wr` is high. Read data is a combinational function of `bus_addr`, and it may be sampled while `bus_rd` is high.

Top module: `cap_timer`

## Requirements
- R1: With a nonzero clock select and clear-on-match off, each clock edge with `tick` high adds one to the counter, and the count wraps from 0xFFFF to 0x0000.
- R2: With clock select zero the counter holds its value whatever `tick` does, and it can still be written and read through addresses 1 and 2.
- R3: A write to address 1 loads the counter with {staging latch, write data}. This load takes precedence over an increment or a clear in the same cycle.
- R4: With clear-on-match on, an enabled tick while the counter equals {0x00, compare A} returns the counter to zero.
- R5: The overflow flag (bit 0) is set on the enabled tick that advances the counter from 0xFFFF.
- R6: Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. If a set event for that flag occurs in the same cycle as the clear, the flag stays set.
- R7: Reading address 1 returns the counter's low byte and copies the high byte into the staging latch, which address 2 returns. Writing address 2 changes only the staging latch, not the counter.
- R8: With capture enabled, a filtered transition on `cap_pin` matching the polarity bit copies the counter's low byte into compare A and sets the capture flag (bit 1) in the same cycle. A transition of the opposite polarity does nothing.
- R9: In narrow capture mode, compare B is left unchanged by a capture and still raises match B. Match A is suppressed.
- R10: In wide capture mode, a capture also writes the counter's high byte into compare B, and neither match flag can be set.
- R11: With the noise filter on, a pin level lasting fewer than four synchronized samples produces no capture. With the filter off, a two-cycle pulse captures.
- R12: Outside the modes that suppress it, an enabled tick while the counter equals {0x00, compare X} sets match flag X (A is bit 2, B is bit 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Prescaled count enable |
| cap_pin | input | 1 | Asynchronous capture input |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (drives the staging latch) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| ovf_flag | output | 1 | Overflow flag |
| cap_flag | output | 1 | Capture flag |
| match_a_flag | output | 1 | Compare A match flag |
| match_b_flag | output | 1 | Compare B match flag |

## Verification
Two kinds of collision can fall in the same cycle. The first is a software load of the counter landing on the edge where `tick` would advance it. The bench holds `tick` high across the write strobe, reads the counter back, and expects the written value rather than that value plus one. The second is a write-one clear of the overflow flag landing on the edge where the counter wraps from 0xFFFF. Here the bench expects the flag still set afterwards, and expects a later clear with `tick` low to take effect.

// File: rtl/cap_timer_pkg.sv
package cap_timer_pkg;
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd1;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd2;
  localparam logic [ADDR_W-1:0] A_CMP_A  = 3'd3;
  localparam logic [ADDR_W-1:0] A_CMP_B  = 3'd4;
  localparam logic [ADDR_W-1:0] A_FLAGS  = 3'd5;

  localparam int unsigned FLAG_N    = 4;
  localparam int unsigned F_OVF     = 0;
  localparam int unsigned F_CAP     = 1;
  localparam int unsigned F_MATCH_A = 2;
  localparam int unsigned F_MATCH_B = 3;

  typedef struct packed {
    logic       nc_en;
    logic       rise;
    logic       cap16;
    logic       cap_en;
    logic       ctc;
    logic [2:0] clk_sel;
  } ctrl_t;
endpackage

// File: rtl/cap_timer_edge.sv
module cap_timer_edge #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned NC_SAMPLES  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic nc_en,
  input  logic rise_sel,
  output logic edge_hit
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [NC_SAMPLES-1:0]  hist_q;
  logic                   filt_q;
  logic                   filt_d_q;
  logic                   smp;

  assign smp = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q   <= '0;
      hist_q   <= '0;
      filt_q   <= 1'b0;
      filt_d_q <= 1'b0;
    end else begin
      sync_q   <= {sync_q[SYNC_STAGES-2:0], pin};
      hist_q   <= {hist_q[NC_SAMPLES-2:0], smp};
      filt_d_q <= filt_q;
      if (!nc_en)          filt_q <= smp;
      else if (&hist_q)    filt_q <= 1'b1;
      else if (~|hist_q)   filt_q <= 1'b0;
    end
  end

  assign edge_hit = rise_sel ? (filt_q & ~filt_d_q) : (~filt_q & filt_d_q);
endmodule

// File: rtl/cap_timer_count.sv
module cap_timer_count #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          ctc,
  input  logic [CW-1:0] top,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic [CW-1:0] cnt,
  output logic          wrap
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (load)               cnt <= load_val;
    else if (run) begin
      if (ctc && cnt == top)     cnt <= '0;
      else                       cnt <= cnt + 1'b1;
    end
  end

  assign wrap = run && !load && (&cnt);
endmodule

// File: rtl/cap_timer.sv
module cap_timer
  import cap_timer_pkg::*;
#(
  parameter int unsigned BYTE_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned NC_SAMPLES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              cap_pin,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic              ovf_flag,
  output logic              cap_flag,
  output logic              match_a_flag,
  output logic              match_b_flag
);
  localparam int unsigned CW    = 2 * BYTE_W;
  localparam int unsigned N_CMP = 2;

  ctrl_t                        ctrl_q;
  logic [N_CMP-1:0][BYTE_W-1:0] cmp_q;
  logic [BYTE_W-1:0]            temp_q;
  logic [FLAG_N-1:0]            flags_q;
  logic [CW-1:0]                cnt_q;
  logic                         wrap;
  logic                         edge_hit;
  logic                         cap_evt;
  logic                         run;
  logic                         wr_lo;
  logic [N_CMP-1:0]             cmp_en;
  logic [N_CMP-1:0]             match_evt;
  logic [FLAG_N-1:0]            flag_set;
  logic [FLAG_N-1:0]            flag_clr;

  assign wr_lo   = bus_wr && bus_addr == A_CNT_LO;
  assign run     = (ctrl_q.clk_sel != 3'd0) && tick;
  assign cap_evt = edge_hit && ctrl_q.cap_en;

  cap_timer_edge #(.SYNC_STAGES(SYNC_STAGES), .NC_SAMPLES(NC_SAMPLES)) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin      (cap_pin),
    .nc_en    (ctrl_q.nc_en),
    .rise_sel (ctrl_q.rise),
    .edge_hit (edge_hit)
  );

  cap_timer_count #(.CW(CW)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .ctc      (ctrl_q.ctc),
    .top      ({{BYTE_W{1'b0}}, cmp_q[0]}),
    .load     (wr_lo),
    .load_val ({temp_q, bus_wdata}),
    .cnt      (cnt_q),
    .wrap     (wrap)
  );

  // compare A is suppressed by any capture mode; B only by wide capture
  assign cmp_en[0] = !ctrl_q.cap_en;
  assign cmp_en[1] = !(ctrl_q.cap_en && ctrl_q.cap16);

  for (genvar i = 0; i < N_CMP; i++) begin : g_cmp
    logic wr_this;
    logic cap_this;
    assign wr_this      = bus_wr && bus_addr == (i == 0 ? A_CMP_A : A_CMP_B);
    assign cap_this     = cap_evt && (i == 0 || ctrl_q.cap16);
    assign match_evt[i] = run && cmp_en[i] && cnt_q == {{BYTE_W{1'b0}}, cmp_q[i]};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cmp_q[i] <= '0;
      else if (cap_this) cmp_q[i] <= cnt_q[i*BYTE_W +: BYTE_W];
      else if (wr_this)  cmp_q[i] <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      temp_q <= '0;
    end else begin
      if (bus_wr && bus_addr == A_CTRL) ctrl_q <= ctrl_t'(bus_wdata);
      if (bus_wr && bus_addr == A_CNT_HI)     temp_q <= bus_wdata;
      else if (bus_rd && bus_addr == A_CNT_LO) temp_q <= cnt_q[CW-1:BYTE_W];
    end
  end

  always_comb begin
    flag_set            = '0;
    flag_set[F_OVF]     = wrap;
    flag_set[F_CAP]     = cap_evt;
    flag_set[F_MATCH_A] = match_evt[0];
    flag_set[F_MATCH_B] = match_evt[1];
    flag_clr = (bus_wr && bus_addr == A_FLAGS) ? bus_wdata[FLAG_N-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (flags_q & ~flag_clr) | flag_set;
  end

  always_comb begin
    case (bus_addr)
      A_CTRL:   bus_rdata = ctrl_q;
      A_CNT_LO: bus_rdata = cnt_q[BYTE_W-1:0];
      A_CNT_HI: bus_rdata = temp_q;
      A_CMP_A:  bus_rdata = cmp_q[0];
      A_CMP_B:  bus_rdata = cmp_q[1];
      A_FLAGS:  bus_rdata = {{(BYTE_W-FLAG_N){1'b0}}, flags_q};
      default:  bus_rdata = '0;
    endcase
  end

  assign ovf_flag     = flags_q[F_OVF];
  assign cap_flag     = flags_q[F_CAP];
  assign match_a_flag = flags_q[F_MATCH_A];
  assign match_b_flag = flags_q[F_MATCH_B];
endmodule

// File: rtl/cap_timer_sva.sv
module cap_timer_sva #(
  parameter int unsigned BYTE_W = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     tick,
  input logic                     wr_lo,
  input logic [BYTE_W-1:0]        bus_wdata,
  input logic [7:0]               ctrl,
  input logic [2*BYTE_W-1:0]      cnt,
  input logic [1:0][BYTE_W-1:0]   cmp_q,
  input logic [3:0]               flags,
  input logic                     cap_evt
);
  localparam int unsigned CW = 2 * BYTE_W;

  p_inc_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && ctrl[2:0] != 3'd0 && !ctrl[3] && !wr_lo) |=> cnt == CW'($past(cnt) + 1'b1));

  p_stop_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[2:0] == 3'd0 && !wr_lo) |=> $stable(cnt));

  p_cpu_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> cnt[BYTE_W-1:0] == $past(bus_wdata));

  p_ovf_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && ctrl[2:0] != 3'd0 && (&cnt) && !wr_lo) |=> flags[0]);

  p_cap_copy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (cmp_q[0] == $past(cnt[BYTE_W-1:0]) && flags[1]));

  p_hi_copy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_evt && ctrl[5]) |=> cmp_q[1] == $past(cnt[CW-1:BYTE_W]));

  p_no_match_wide_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[4] && ctrl[5] && !flags[3]) |=> !flags[3]);
endmodule

bind cap_timer cap_timer_sva #(.BYTE_W(BYTE_W)) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (tick),
  .wr_lo     (wr_lo),
  .bus_wdata (bus_wdata),
  .ctrl      (ctrl_q),
  .cnt       (cnt_q),
  .cmp_q     (cmp_q),
  .flags     (flags_q),
  .cap_evt   (cap_evt)
);

// File: tb/cap_timer_test.sv
module cap_timer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       cap_pin = 1'b0;
  logic [2:0] bus_addr = 3'd0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       ovf_flag, cap_flag, match_a_flag, match_b_flag;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cap_timer uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cap_pin(cap_pin),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ovf_flag(ovf_flag), .cap_flag(cap_flag),
    .match_a_flag(match_a_flag), .match_b_flag(match_b_flag)
  );

  task automatic check(input string what, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic set_cnt(input logic [15:0] v);
    wr_reg(3'd2, v[15:8]);
    wr_reg(3'd1, v[7:0]);
  endtask

  task automatic get_cnt(output logic [15:0] v);
    logic [7:0] lo, hi;
    rd_reg(3'd1, lo);
    rd_reg(3'd2, hi);
    v = {hi, lo};
  endtask

  task automatic pulse_tick(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd_reg(3'd0, d);
    check("R2 reset control", {8'd0, d}, 16'h0000);
    check("R6 reset flags", {12'd0, match_b_flag, match_a_flag, cap_flag, ovf_flag}, 16'h0000);
  endtask

  task automatic t_count;
    logic [15:0] v;
    wr_reg(3'd0, 8'h01);
    set_cnt(16'h0010);
    pulse_tick(5);
    get_cnt(v);
    check("R1 five ticks", v, 16'h0015);
    set_cnt(16'hFFFF);
    pulse_tick(2);
    get_cnt(v);
    check("R1 wrap through zero", v, 16'h0001);
  endtask

  task automatic t_stop;
    logic [15:0] v;
    wr_reg(3'd0, 8'h00);
    set_cnt(16'h1234);
    pulse_tick(6);
    get_cnt(v);
    check("R2 stopped counter holds and is writable", v, 16'h1234);
  endtask

  task automatic t_cpu_priority;
    logic [15:0] v;
    wr_reg(3'd0, 8'h01);
    wr_reg(3'd2, 8'h56);
    @(negedge clk);
    tick = 1'b1; bus_addr = 3'd1; bus_wdata = 8'h78; bus_wr = 1'b1;
    @(negedge clk);
    tick = 1'b0; bus_wr = 1'b0;
    get_cnt(v);
    check("R3 write beats increment", v, 16'h5678);
  endtask

  task automatic t_ctc;
    logic [15:0] v;
    wr_reg(3'd5, 8'h0F);
    wr_reg(3'd3, 8'h03);
    wr_reg(3'd0, 8'h09);
    set_cnt(16'h0000);
    pulse_tick(4);
    get_cnt(v);
    check("R4 clear at compare A", v, 16'h0000);
    pulse_tick(2);
    get_cnt(v);
    check("R4 restart after clear", v, 16'h0002);
    check("R12 match A in clear mode", {15'd0, match_a_flag}, 16'h0001);
  endtask

  task automatic t_ovf;
    logic [15:0] v;
    wr_reg(3'd0, 8'h01);
    set_cnt(16'hFFFE);
    wr_reg(3'd5, 8'h0F);
    pulse_tick(1);
    check("R5 no overflow at FFFF", {15'd0, ovf_flag}, 16'h0000);
    @(negedge clk);
    tick = 1'b1; bus_addr = 3'd5; bus_wdata = 8'h01; bus_wr = 1'b1;
    @(negedge clk);
    tick = 1'b0; bus_wr = 1'b0;
    check("R6 set wins over clear", {15'd0, ovf_flag}, 16'h0001);
    get_cnt(v);
    check("R5 counter wrapped", v, 16'h0000);
    wr_reg(3'd5, 8'h01);
    check("R6 write-one clears", {15'd0, ovf_flag}, 16'h0000);
  endtask

  task automatic t_temp;
    logic [7:0] d;
    wr_reg(3'd0, 8'h00);
    set_cnt(16'hABCD);
    rd_reg(3'd1, d);
    check("R7 low byte read", {8'd0, d}, 16'h00CD);
    rd_reg(3'd2, d);
    check("R7 latched high byte", {8'd0, d}, 16'h00AB);
    wr_reg(3'd2, 8'h11);
    rd_reg(3'd1, d);
    check("R7 high write leaves counter", {8'd0, d}, 16'h00CD);
    rd_reg(3'd2, d);
    check("R7 relatch high byte", {8'd0, d}, 16'h00AB);
  endtask

  task automatic t_edge;
    logic [7:0] d;
    wr_reg(3'd0, 8'h50);
    wr_reg(3'd5, 8'h0F);
    set_cnt(16'h0042);
    cap_pin = 1'b1;
    idle(8);
    rd_reg(3'd3, d);
    check("R8 rising capture value", {8'd0, d}, 16'h0042);
    check("R8 capture flag", {15'd0, cap_flag}, 16'h0001);
    wr_reg(3'd5, 8'h0F);
    wr_reg(3'd0, 8'h10);
    set_cnt(16'h0077);
    cap_pin = 1'b0;
    idle(8);
    rd_reg(3'd3, d);
    check("R8 falling capture value", {8'd0, d}, 16'h0077);
    wr_reg(3'd5, 8'h0F);
    set_cnt(16'h0033);
    cap_pin = 1'b1;
    idle(8);
    rd_reg(3'd3, d);
    check("R8 wrong edge ignored value", {8'd0, d}, 16'h0077);
    check("R8 wrong edge ignored flag", {15'd0, cap_flag}, 16'h0000);
    cap_pin = 1'b0;
    idle(8);
    rd_reg(3'd3, d);
    check("R8 falling after ignored rise", {8'd0, d}, 16'h0033);
  endtask

  task automatic t_cap8;
    logic [7:0] d;
    wr_reg(3'd0, 8'h50);
    wr_reg(3'd4, 8'h07);
    set_cnt(16'h0003);
    cap_pin = 1'b1;
    idle(8);
    rd_reg(3'd3, d);
    check("R9 narrow capture into A", {8'd0, d}, 16'h0003);
    rd_reg(3'd4, d);
    check("R9 compare B untouched", {8'd0, d}, 16'h0007);
    wr_reg(3'd5, 8'h0F);
    wr_reg(3'd0, 8'h51);
    set_cnt(16'h0000);
    pulse_tick(8);
    check("R9 match B active", {15'd0, match_b_flag}, 16'h0001);
    check("R9 match A suppressed", {15'd0, match_a_flag}, 16'h0000);
  endtask

  task automatic t_cap16;
    logic [7:0] d;
    wr_reg(3'd0, 8'h30);
    wr_reg(3'd5, 8'h0F);
    set_cnt(16'hBEEF);
    cap_pin = 1'b0;
    idle(8);
    rd_reg(3'd3, d);
    check("R10 wide low byte", {8'd0, d}, 16'h00EF);
    rd_reg(3'd4, d);
    check("R10 wide high byte", {8'd0, d}, 16'h00BE);
    wr_reg(3'd5, 8'h0F);
    wr_reg(3'd0, 8'h31);
    set_cnt(16'h00E0);
    pulse_tick(20);
    check("R10 match flags suppressed", {14'd0, match_b_flag, match_a_flag}, 16'h0000);
  endtask

  task automatic t_noise;
    logic [7:0] d;
    wr_reg(3'd0, 8'hD0);
    wr_reg(3'd5, 8'h0F);
    set_cnt(16'h0021);
    idle(8);
    @(negedge clk); cap_pin = 1'b1;
    idle(2);        cap_pin = 1'b0;
    idle(10);
    check("R11 short pulse filtered", {15'd0, cap_flag}, 16'h0000);
    rd_reg(3'd3, d);
    check("R11 filtered value kept", {8'd0, d}, 16'h00EF);
    cap_pin = 1'b1;
    idle(12);
    rd_reg(3'd3, d);
    check("R11 long level captured", {8'd0, d}, 16'h0021);
    cap_pin = 1'b0;
    idle(10);
    wr_reg(3'd0, 8'h50);
    wr_reg(3'd5, 8'h0F);
    set_cnt(16'h0044);
    @(negedge clk); cap_pin = 1'b1;
    idle(2);        cap_pin = 1'b0;
    idle(8);
    check("R11 unfiltered short pulse flag", {15'd0, cap_flag}, 16'h0001);
    rd_reg(3'd3, d);
    check("R11 unfiltered short pulse value", {8'd0, d}, 16'h0044);
  endtask

  task automatic t_match;
    wr_reg(3'd0, 8'h01);
    wr_reg(3'd3, 8'h05);
    wr_reg(3'd4, 8'h09);
    wr_reg(3'd5, 8'h0F);
    set_cnt(16'h0000);
    pulse_tick(6);
    check("R12 match A set", {15'd0, match_a_flag}, 16'h0001);
    check("R12 match B not reached", {15'd0, match_b_flag}, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_count();
    t_stop();
    t_cpu_priority();
    t_ctc();
    t_ovf();
    t_temp();
    t_edge();
    t_cap8();
    t_cap16();
    t_noise();
    t_match();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog (R1..R12 run incomplete): actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule